// File: doc/BRIEF.md
# Pointer-Indexed Hybrid Wakeup Window

This block is the wakeup half of an out-of-order issue window with N slots. Each slot keeps a destination tag, two source tags with a ready flag each, and one forward link to a waiting consumer. The link is written when a consumer arrives with an operand that is not yet available. When a producer later completes, the block normally fires only the comparator of the one consumer named by that link. A producer that has gathered more than one waiting consumer falls back to a tag broadcast. During that broadcast, only slots marked as listeners take part in the comparison.

Dispatch accepts one instruction per cycle. The instruction arrives with the slot it goes into, and with the slot index of the producer of each source. A completion port names the slot of the finishing producer, and that slot is freed. A squash mask drops slots, and any links that still point at dropped slots are tolerated. The block reports, combinationally, how many comparators the current completion enables. A parameter swaps the broadcast fallback for a stall mode: in that mode, dispatch is refused while a needed producer's link is already taken. Selection, arbitration and execution are outside the block.

Top module: `hybrid_wakeup_window`

## Requirements
- R1: After reset every slot is invalid (`entry_valid` = 0, `entry_ready` = 0) and `cmp_enable_cnt` reads 0.
- R2: An accepted dispatch into slot s sets bit s of `entry_valid` from the next cycle. Each source flag given as ready marks that source ready.
- R3: A completing producer with exactly one linked consumer and no broadcast mark enables exactly one comparator (`cmp_enable_cnt` = 1) in its completion cycle. The matching source of the consumer is ready from the next cycle.
- R4: A completing producer with no linked consumer enables no comparator (count 0). Any completion frees the producer's slot from the next cycle.
- R5: A second waiting consumer of one producer turns that producer into a broadcaster. The count then equals the number of valid listener slots: 2 for two consumers, 3 after a third. Every one of them becomes ready.
- R6: A consumer whose two sources come from the same producer uses the single link. The completion enables one comparator and readies both sources.
- R7: A consumer with two unready sources from different producers is linked to both. It becomes ready only after the second producer completes.
- R8: A squash clears `entry_valid` for every set mask bit. A stale link left in a surviving producer never prevents a later consumer's wakeup. A listener slot that is no longer valid is not counted.
- R9: A dispatch whose producer completes in the same cycle treats that source as ready.
- R10: With STALL_MODE=1, `disp_accept` is low while any unready source's producer already holds a link, and the refused dispatch leaves the slot invalid. With STALL_MODE=0, `disp_accept` is always high.
- R11: Bit i of `entry_ready` is high exactly when slot i is valid and both of its sources are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_slot | input | IDXW | Slot receiving the instruction |
| disp_dst | input | TAGW | Destination tag |
| disp_src0_tag | input | TAGW | Source 0 tag |
| disp_src0_rdy | input | 1 | Source 0 already available |
| disp_src0_prod | input | IDXW | Slot of source 0's producer |
| disp_src1_tag | input | TAGW | Source 1 tag |
| disp_src1_rdy | input | 1 | Source 1 already available |
| disp_src1_prod | input | IDXW | Slot of source 1's producer |
| disp_accept | output | 1 | Dispatch taken this cycle |
| cmp_valid | input | 1 | A producer completes |
| cmp_slot | input | IDXW | Slot of the completing producer |
| squash_mask | input | N | Slots to drop |
| entry_valid | output | N | Slot occupancy |
| entry_ready | output | N | Slot has both sources ready |
| cmp_enable_cnt | output | CNTW | Comparators enabled by the current completion |

## Verification
Two kinds of result come out of the block, and each is due at a different time. `cmp_enable_cnt` and `disp_accept` are combinational. The bench therefore samples them one nanosecond after it drives the inputs on a falling edge, before the next rising edge. `entry_valid` and `entry_ready` come from registers, so their effect appears one rising edge after the stimulus. The bench reads them on the following falling edge, when the inputs have already returned to idle. Each scenario starts from a fresh reset, so the expected counts follow only from the links made within that scenario.

// File: rtl/hw_pkg.sv
package hw_pkg;
    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_INDEX = 2'd1,
        WK_BCAST = 2'd2
    } wake_kind_e;
endpackage

// File: rtl/hw_enable_gen.sv
module hw_enable_gen
    import hw_pkg::*;
#(
    parameter int N    = 8,
    parameter int IDXW = $clog2(N),
    parameter int CNTW = $clog2(N + 1)
) (
    input  wake_kind_e      kind,
    input  logic [IDXW-1:0] link,
    input  logic [IDXW-1:0] src_slot,
    input  logic [N-1:0]    listen,
    input  logic [N-1:0]    valid,
    output logic [N-1:0]    enable,
    output logic [CNTW-1:0] count
);
    always_comb begin
        enable = '0;
        unique case (kind)
            WK_INDEX: enable[link] = 1'b1;
            WK_BCAST: begin
                enable = listen & valid;
                enable[src_slot] = 1'b0;
            end
            default: enable = '0;
        endcase
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CNTW'(enable[i]);
        end
    end
endmodule

// File: rtl/hw_tag_match.sv
module hw_tag_match #(
    parameter int N    = 8,
    parameter int TAGW = 6
) (
    input  logic [N-1:0]           enable,
    input  logic [TAGW-1:0]        tag,
    input  logic [N-1:0][TAGW-1:0] s0_tag,
    input  logic [N-1:0][TAGW-1:0] s1_tag,
    input  logic [N-1:0]           s0_rdy,
    input  logic [N-1:0]           s1_rdy,
    output logic [N-1:0]           set0,
    output logic [N-1:0]           set1
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign set0[i] = enable[i] && !s0_rdy[i] && (s0_tag[i] == tag);
        assign set1[i] = enable[i] && !s1_rdy[i] && (s1_tag[i] == tag);
    end
endmodule

// File: rtl/hybrid_wakeup_window.sv
module hybrid_wakeup_window
    import hw_pkg::*;
#(
    parameter int N          = 8,
    parameter int TAGW       = 6,
    parameter bit STALL_MODE = 1'b0,
    localparam int IDXW      = $clog2(N),
    localparam int CNTW      = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp_valid,
    input  logic [IDXW-1:0] disp_slot,
    input  logic [TAGW-1:0] disp_dst,
    input  logic [TAGW-1:0] disp_src0_tag,
    input  logic            disp_src0_rdy,
    input  logic [IDXW-1:0] disp_src0_prod,
    input  logic [TAGW-1:0] disp_src1_tag,
    input  logic            disp_src1_rdy,
    input  logic [IDXW-1:0] disp_src1_prod,
    output logic            disp_accept,
    input  logic            cmp_valid,
    input  logic [IDXW-1:0] cmp_slot,
    input  logic [N-1:0]    squash_mask,
    output logic [N-1:0]    entry_valid,
    output logic [N-1:0]    entry_ready,
    output logic [CNTW-1:0] cmp_enable_cnt
);
    typedef struct packed {
        logic [N-1:0]           vld;
        logic [N-1:0][TAGW-1:0] s0t;
        logic [N-1:0][TAGW-1:0] s1t;
        logic [N-1:0]           s0r;
        logic [N-1:0]           s1r;
        logic [N-1:0][TAGW-1:0] dst;
        logic [N-1:0][IDXW-1:0] link;
        logic [N-1:0]           free;
        logic [N-1:0]           bcast;
        logic [N-1:0]           snoop;
    } state_t;

    state_t q, d;

    logic            fire;
    wake_kind_e      kind;
    logic [N-1:0]    cmp_en;
    logic [N-1:0]    set0, set1;
    logic [N-1:0]    bcast_vec, snoop_vec;
    logic [1:0][IDXW-1:0] prod;
    logic [1:0]           src_rdy;

    assign bcast_vec = q.bcast;
    assign snoop_vec = q.snoop;
    assign fire      = cmp_valid && q.vld[cmp_slot];

    always_comb begin
        if (!fire)                 kind = WK_NONE;
        else if (q.bcast[cmp_slot]) kind = WK_BCAST;
        else if (!q.free[cmp_slot]) kind = WK_INDEX;
        else                       kind = WK_NONE;
    end

    hw_enable_gen #(.N(N), .IDXW(IDXW), .CNTW(CNTW)) u_en (
        .kind     (kind),
        .link     (q.link[cmp_slot]),
        .src_slot (cmp_slot),
        .listen   (snoop_vec),
        .valid    (q.vld),
        .enable   (cmp_en),
        .count    (cmp_enable_cnt)
    );

    hw_tag_match #(.N(N), .TAGW(TAGW)) u_match (
        .enable (cmp_en),
        .tag    (q.dst[cmp_slot]),
        .s0_tag (q.s0t),
        .s1_tag (q.s1t),
        .s0_rdy (q.s0r),
        .s1_rdy (q.s1r),
        .set0   (set0),
        .set1   (set1)
    );

    always_comb begin
        prod[0]    = disp_src0_prod;
        prod[1]    = disp_src1_prod;
        src_rdy[0] = disp_src0_rdy || (fire && disp_src0_prod == cmp_slot);
        src_rdy[1] = disp_src1_rdy || (fire && disp_src1_prod == cmp_slot);
        disp_accept = 1'b1;
        if (STALL_MODE) begin
            for (int k = 0; k < 2; k++) begin
                if (!src_rdy[k] && !q.free[prod[k]]) disp_accept = 1'b0;
            end
        end
    end

    always_comb begin
        d = q;
        d.s0r = q.s0r | set0;
        d.s1r = q.s1r | set1;
        if (fire) d.vld[cmp_slot] = 1'b0;
        d.vld = d.vld & ~squash_mask;
        if (disp_valid && disp_accept) begin
            d.vld[disp_slot]   = 1'b1;
            d.s0t[disp_slot]   = disp_src0_tag;
            d.s1t[disp_slot]   = disp_src1_tag;
            d.dst[disp_slot]   = disp_dst;
            d.s0r[disp_slot]   = src_rdy[0];
            d.s1r[disp_slot]   = src_rdy[1];
            d.link[disp_slot]  = '0;
            d.free[disp_slot]  = 1'b1;
            d.bcast[disp_slot] = 1'b0;
            d.snoop[disp_slot] = 1'b0;
            for (int k = 0; k < 2; k++) begin
                if (!src_rdy[k]) begin
                    if (d.free[prod[k]]) begin
                        d.link[prod[k]] = disp_slot;
                        d.free[prod[k]] = 1'b0;
                    end else if (d.link[prod[k]] != disp_slot) begin
                        if (!d.bcast[prod[k]]) begin
                            d.bcast[prod[k]] = 1'b1;
                            d.snoop[d.link[prod[k]]] = 1'b1;
                        end
                        d.snoop[disp_slot] = 1'b1;
                    end
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            if (d.s0r[i] && d.s1r[i]) d.snoop[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.free <= '1;
        end else begin
            q <= d;
        end
    end

    assign entry_valid = q.vld;
    assign entry_ready = q.vld & q.s0r & q.s1r;
endmodule

// File: rtl/hw_wakeup_checker.sv
module hw_wakeup_checker #(
    parameter int N          = 8,
    parameter bit STALL_MODE = 1'b0,
    localparam int IDXW      = $clog2(N),
    localparam int CNTW      = $clog2(N + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            disp_valid,
    input logic [IDXW-1:0] disp_slot,
    input logic            disp_accept,
    input logic            cmp_valid,
    input logic [IDXW-1:0] cmp_slot,
    input logic [N-1:0]    squash_mask,
    input logic [N-1:0]    entry_valid,
    input logic [CNTW-1:0] cmp_enable_cnt,
    input logic [N-1:0]    bcast_vec,
    input logic [N-1:0]    snoop_vec
);
    AST_INDEX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && entry_valid[cmp_slot] && !bcast_vec[cmp_slot]) |-> (cmp_enable_cnt <= 1)); // R3

    AST_BCAST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && entry_valid[cmp_slot] && bcast_vec[cmp_slot])
            |-> (int'(cmp_enable_cnt) <= $countones(snoop_vec))); // R5

    AST_DISP_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_accept) |=> entry_valid[$past(disp_slot)]); // R2

    AST_SQUASH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_mask != '0 && !disp_valid) |=> ((entry_valid & $past(squash_mask)) == '0)); // R8

    AST_HYBRID_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !STALL_MODE |-> disp_accept); // R10

    AST_IDLE_NO_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |-> (cmp_enable_cnt == '0)); // R4
endmodule

bind hybrid_wakeup_window hw_wakeup_checker #(.N(N), .STALL_MODE(STALL_MODE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .disp_valid     (disp_valid),
    .disp_slot      (disp_slot),
    .disp_accept    (disp_accept),
    .cmp_valid      (cmp_valid),
    .cmp_slot       (cmp_slot),
    .squash_mask    (squash_mask),
    .entry_valid    (entry_valid),
    .cmp_enable_cnt (cmp_enable_cnt),
    .bcast_vec      (bcast_vec),
    .snoop_vec      (snoop_vec)
);

// File: tb/sim_hybrid_wakeup_window.sv
module sim_hybrid_wakeup_window;
    localparam int N = 8;
    localparam int TAGW = 6;
    localparam int IDXW = $clog2(N);
    localparam int CNTW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic [IDXW-1:0] disp_slot = '0;
    logic [TAGW-1:0] disp_dst = '0;
    logic [TAGW-1:0] disp_src0_tag = '0;
    logic disp_src0_rdy = 1'b0;
    logic [IDXW-1:0] disp_src0_prod = '0;
    logic [TAGW-1:0] disp_src1_tag = '0;
    logic disp_src1_rdy = 1'b0;
    logic [IDXW-1:0] disp_src1_prod = '0;
    logic cmp_valid = 1'b0;
    logic [IDXW-1:0] cmp_slot = '0;
    logic [N-1:0] squash_mask = '0;

    logic disp_accept, disp_accept_s;
    logic [N-1:0] entry_valid, entry_ready, entry_valid_s, entry_ready_s;
    logic [CNTW-1:0] cmp_enable_cnt, cmp_enable_cnt_s;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hybrid_wakeup_window #(.N(N), .TAGW(TAGW), .STALL_MODE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_slot(disp_slot),
        .disp_dst(disp_dst), .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
        .disp_src0_prod(disp_src0_prod), .disp_src1_tag(disp_src1_tag),
        .disp_src1_rdy(disp_src1_rdy), .disp_src1_prod(disp_src1_prod),
        .disp_accept(disp_accept), .cmp_valid(cmp_valid), .cmp_slot(cmp_slot),
        .squash_mask(squash_mask), .entry_valid(entry_valid), .entry_ready(entry_ready),
        .cmp_enable_cnt(cmp_enable_cnt)
    );

    hybrid_wakeup_window #(.N(N), .TAGW(TAGW), .STALL_MODE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_slot(disp_slot),
        .disp_dst(disp_dst), .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
        .disp_src0_prod(disp_src0_prod), .disp_src1_tag(disp_src1_tag),
        .disp_src1_rdy(disp_src1_rdy), .disp_src1_prod(disp_src1_prod),
        .disp_accept(disp_accept_s), .cmp_valid(cmp_valid), .cmp_slot(cmp_slot),
        .squash_mask(squash_mask), .entry_valid(entry_valid_s), .entry_ready(entry_ready_s),
        .cmp_enable_cnt(cmp_enable_cnt_s)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        disp_valid = 1'b0;
        cmp_valid = 1'b0;
        squash_mask = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_disp(input int slot, input int dst,
                            input int t0, input bit r0, input int p0,
                            input int t1, input bit r1, input int p1);
        disp_valid = 1'b1;
        disp_slot = IDXW'(slot);
        disp_dst = TAGW'(dst);
        disp_src0_tag = TAGW'(t0);
        disp_src0_rdy = r0;
        disp_src0_prod = IDXW'(p0);
        disp_src1_tag = TAGW'(t1);
        disp_src1_rdy = r1;
        disp_src1_prod = IDXW'(p1);
    endtask

    // dispatch one instruction; inputs return to idle on the next falling edge
    task automatic dispatch(input int slot, input int dst,
                            input int t0, input bit r0, input int p0,
                            input int t1, input bit r1, input int p1);
        @(negedge clk);
        set_disp(slot, dst, t0, r0, p0, t1, r1, p1);
        @(negedge clk);
        idle_inputs();
    endtask

    // complete a producer; returns the comparator count seen in its cycle
    task automatic complete(input int slot, output int cnt);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_slot = IDXW'(slot);
        #1;
        cnt = int'(cmp_enable_cnt);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 entry_valid", int'(entry_valid), 0);
        check("R1 entry_ready", int'(entry_ready), 0);
        check("R1 count", int'(cmp_enable_cnt), 0);
    endtask

    task automatic t_indexed();
        int c;
        do_reset();
        dispatch(0, 5, 1, 1'b1, 0, 2, 1'b1, 0);
        check("R2 producer valid", int'(entry_valid[0]), 1);
        check("R11 producer ready", int'(entry_ready[0]), 1);
        dispatch(1, 6, 5, 1'b0, 0, 3, 1'b1, 0);
        check("R2 consumer valid", int'(entry_valid[1]), 1);
        check("R11 consumer not ready", int'(entry_ready[1]), 0);
        complete(0, c);
        check("R3 indexed count", c, 1);
        check("R3 consumer woken", int'(entry_ready[1]), 1);
        check("R4 producer freed", int'(entry_valid[0]), 0);
        complete(1, c);
        check("R4 no consumer count", c, 0);
    endtask

    task automatic t_broadcast();
        int c;
        do_reset();
        dispatch(2, 9, 1, 1'b1, 0, 1, 1'b1, 0);
        dispatch(3, 10, 9, 1'b0, 2, 1, 1'b1, 0);
        dispatch(4, 11, 1, 1'b1, 0, 9, 1'b0, 2);
        complete(2, c);
        check("R5 two listeners count", c, 2);
        check("R5 both woken", int'(entry_ready[4:3]), 3);
        do_reset();
        dispatch(2, 9, 1, 1'b1, 0, 1, 1'b1, 0);
        dispatch(3, 10, 9, 1'b0, 2, 1, 1'b1, 0);
        dispatch(4, 11, 9, 1'b0, 2, 1, 1'b1, 0);
        dispatch(5, 12, 1, 1'b1, 0, 9, 1'b0, 2);
        complete(2, c);
        check("R5 three listeners count", c, 3);
        check("R5 three woken", int'(entry_ready[5:3]), 7);
    endtask

    task automatic t_same_producer();
        int c;
        do_reset();
        dispatch(0, 7, 1, 1'b1, 0, 1, 1'b1, 0);
        dispatch(1, 8, 7, 1'b0, 0, 7, 1'b0, 0);
        complete(0, c);
        check("R6 single link count", c, 1);
        check("R6 both sources ready", int'(entry_ready[1]), 1);
    endtask

    task automatic t_two_producers();
        int c;
        do_reset();
        dispatch(0, 20, 1, 1'b1, 0, 1, 1'b1, 0);
        dispatch(1, 21, 1, 1'b1, 0, 1, 1'b1, 0);
        dispatch(2, 22, 20, 1'b0, 0, 21, 1'b0, 1);
        complete(0, c);
        check("R7 first producer count", c, 1);
        check("R7 not ready after one", int'(entry_ready[2]), 0);
        complete(1, c);
        check("R7 second producer count", c, 1);
        check("R7 ready after both", int'(entry_ready[2]), 1);
    endtask

    task automatic t_squash();
        int c;
        do_reset();
        dispatch(0, 3, 1, 1'b1, 0, 1, 1'b1, 0);
        dispatch(1, 4, 3, 1'b0, 0, 1, 1'b1, 0);
        @(negedge clk);
        squash_mask = 8'b0000_0010;
        @(negedge clk);
        idle_inputs();
        check("R8 squashed slot", int'(entry_valid[1]), 0);
        check("R8 survivor", int'(entry_valid[0]), 1);
        dispatch(2, 5, 3, 1'b0, 0, 1, 1'b1, 0);
        complete(0, c);
        check("R8 stale listener not counted", c, 1);
        check("R8 wake despite stale link", int'(entry_ready[2]), 1);
    endtask

    task automatic t_same_cycle();
        do_reset();
        dispatch(0, 30, 1, 1'b1, 0, 1, 1'b1, 0);
        @(negedge clk);
        set_disp(1, 31, 30, 1'b0, 0, 1, 1'b1, 0);
        cmp_valid = 1'b1;
        cmp_slot = '0;
        @(negedge clk);
        idle_inputs();
        check("R9 same-cycle ready", int'(entry_ready[1]), 1);
    endtask

    task automatic t_stall();
        do_reset();
        dispatch(0, 40, 1, 1'b1, 0, 1, 1'b1, 0);
        dispatch(1, 41, 40, 1'b0, 0, 1, 1'b1, 0);
        @(negedge clk);
        set_disp(2, 42, 40, 1'b0, 0, 1, 1'b1, 0);
        #1;
        check("R10 stall refuses", int'(disp_accept_s), 0);
        check("R10 hybrid accepts", int'(disp_accept), 1);
        @(negedge clk);
        idle_inputs();
        check("R10 refused slot empty", int'(entry_valid_s[2]), 0);
        check("R10 hybrid slot filled", int'(entry_valid[2]), 1);
    endtask

    initial begin
        t_reset();
        t_indexed();
        t_broadcast();
        t_same_producer();
        t_two_producers();
        t_squash();
        t_same_cycle();
        t_stall();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule